// File: doc/BRIEF.md
# Immediate-Add Data Path with Arithmetic Status Flags

This block holds a small file of data registers and, on each execute strobe, adds a signed short immediate to the register chosen by an index. The sum is written back into that register. On the same clock edge a status word is updated with zero, negative, carry and signed-overflow flags. Each add writes the carry and the overflow flag twice, once into the main bit and once into a duplicate bit, so that later logic can read either one.

A sticky overflow bit collects every overflow since the status word was last written. Adds never clear it. A status-write port replaces the whole status word at once, and that is the only way to clear the sticky bit or to preset the flags. A register-load port lets surrounding logic place arbitrary values in the register file without touching the flags.

Top module: `imm_add_alu`

## Requirements
- R1: When `exec_en` is high, register `reg_sel` takes the value (old value + sign-extended `imm`) modulo 2^32 at the next rising clock edge. All other registers keep their values.
- R2: After an add, status bit 0 (zero flag) is 1 exactly when the 32-bit result is zero.
- R3: After an add, status bit 1 (negative flag) equals bit 31 of the result.
- R4: After an add, status bit 2 (carry flag) is the unsigned carry out of bit 31, and status bit 3 holds the same value.
- R5: After an add, status bit 4 (overflow flag) is 1 exactly when the signed sum falls outside the 32-bit two's-complement range, and status bit 5 holds the same value.
- R6: Status bit 6 (sticky overflow) becomes 1 after any add that overflows. An add without overflow leaves it unchanged.
- R7: When `stat_wr_en` is high, the whole status word becomes `stat_wr_data` at the next edge. This takes priority over the flag update of an add in the same cycle, while that add still writes its register.
- R8: Status bits 7 to 31 are left unchanged by an add.
- R9: When `ld_en` is high, register `ld_sel` takes `ld_data` at the next edge and no status bit changes. If an add targets the same register in the same cycle, the add result is written and the load is dropped.
- R10: While `rst_n` is low, all registers and the status word read zero.
- R11: With `exec_en`, `ld_en` and `stat_wr_en` all low, neither the registers nor the status word change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| exec_en | input | 1 | Perform the immediate add this cycle |
| reg_sel | input | 3 | Index of the register the add reads and writes |
| imm | input | 7 | Signed immediate operand |
| ld_en | input | 1 | Load a register directly |
| ld_sel | input | 3 | Index of the register to load |
| ld_data | input | 32 | Value to load |
| stat_wr_en | input | 1 | Overwrite the whole status word |
| stat_wr_data | input | 32 | New status word |
| regs_flat | output | 256 | All registers; register i occupies bits [32*i+31:32*i] |
| status | output | 32 | Status word |

## Verification
Two pairs of operations can fall in the same cycle. The first is an add and a status write: the write must win over the flag update, yet the register must still take the sum. The second is an add and a load aimed at the same register: the sum must be stored and the load dropped. Directed cycles assert both strobes together, including a case where the written word clears the sticky bit while the add overflows. The random phase also raises the strobes together by chance. After every edge, a bench model compares each register and the full status word.

// File: rtl/imm_add_alu.sv
module imm_add_alu #(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int IMM_W = 7,
  parameter int SW    = 32,
  parameter int ZF    = 0,
  parameter int NF    = 1,
  parameter int CF    = 2,
  parameter int CFD   = 3,
  parameter int VF    = 4,
  parameter int VFD   = 5,
  parameter int VS    = 6,
  localparam int SELW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_en,
  input  logic [SELW-1:0]      reg_sel,
  input  logic [IMM_W-1:0]     imm,
  input  logic                 ld_en,
  input  logic [SELW-1:0]      ld_sel,
  input  logic [DW-1:0]        ld_data,
  input  logic                 stat_wr_en,
  input  logic [SW-1:0]        stat_wr_data,
  output logic [NREG*DW-1:0]   regs_flat,
  output logic [SW-1:0]        status
);

  localparam logic [SW-1:0] FLAG_MASK = (SW'(1) << ZF) | (SW'(1) << NF) | (SW'(1) << CF) |
                                        (SW'(1) << CFD) | (SW'(1) << VF) | (SW'(1) << VFD) |
                                        (SW'(1) << VS);

  logic [DW-1:0] rf [NREG];
  logic [SW-1:0] st_q, st_nxt;
  logic [DW-1:0] opnd, immx, sum;
  logic          carry, ovf;

  assign opnd         = rf[reg_sel];
  assign immx         = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
  assign {carry, sum} = {1'b0, opnd} + {1'b0, immx};
  assign ovf          = (opnd[DW-1] == immx[DW-1]) && (sum[DW-1] != opnd[DW-1]);

  always_comb begin
    st_nxt      = st_q;
    st_nxt[ZF]  = (sum == '0);
    st_nxt[NF]  = sum[DW-1];
    st_nxt[CF]  = carry;
    st_nxt[CFD] = carry;
    st_nxt[VF]  = ovf;
    st_nxt[VFD] = ovf;
    st_nxt[VS]  = st_q[VS] | ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      st_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (exec_en && reg_sel == SELW'(i))
          rf[i] <= sum;
        else if (ld_en && ld_sel == SELW'(i))
          rf[i] <= ld_data;
      end
      if (stat_wr_en)
        st_q <= stat_wr_data;
      else if (exec_en)
        st_q <= st_nxt;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = rf[g];
  end
  assign status = st_q;

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !stat_wr_en) |=> status[ZF] == (rf[$past(reg_sel)] == '0));

  p_neg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !stat_wr_en) |=> status[NF] == rf[$past(reg_sel)][DW-1]);

  p_dup_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !stat_wr_en) |=> status[CF] == status[CFD]);

  p_dup_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !stat_wr_en) |=> status[VF] == status[VFD]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[VS] && !stat_wr_en) |=> status[VS]);

  p_wr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en |=> status == $past(stat_wr_data));

  p_hold_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_en |=> (status & ~FLAG_MASK) == ($past(status) & ~FLAG_MASK));

  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !stat_wr_en) |=> $stable(status));

endmodule

// File: tb/imm_add_alu_tb.sv
`timescale 1ns/1ps
module imm_add_alu_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec_en = 1'b0, ld_en = 1'b0, stat_wr_en = 1'b0;
  logic [2:0]   reg_sel = '0, ld_sel = '0;
  logic [6:0]   imm = '0;
  logic [31:0]  ld_data = '0, stat_wr_data = '0;
  logic [255:0] regs_flat;
  logic [31:0]  status;

  int errors = 0, checks = 0;
  logic [31:0] m_rf [8];
  logic [31:0] m_st;

  imm_add_alu u_dut (.clk, .rst_n, .exec_en, .reg_sel, .imm, .ld_en, .ld_sel, .ld_data,
                     .stat_wr_en, .stat_wr_data, .regs_flat, .status);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(string rtag, string stag);
    for (int i = 0; i < 8; i++) check(rtag, regs_flat[i*32 +: 32], m_rf[i]);
    check(stag, status, m_st);
  endtask

  function automatic logic [31:0] add_flags(input logic [31:0] a, input logic [6:0] k,
                                            input logic [31:0] old, output logic [31:0] res);
    logic [31:0] ext;
    logic [32:0] wide;
    longint      s;
    logic [31:0] f;
    ext  = {{25{k[6]}}, k};
    wide = {1'b0, a} + {1'b0, ext};
    res  = wide[31:0];
    s    = longint'($signed(a)) + longint'($signed(ext));
    f    = old;
    f[0] = (res == 32'd0);
    f[1] = res[31];
    f[2] = wide[32];
    f[3] = wide[32];
    f[4] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    f[5] = f[4];
    f[6] = old[6] | f[4];
    return f;
  endfunction

  task automatic step(bit ex, int sel, int k, bit ld, int lsel, logic [31:0] ldv,
                      bit sw, logic [31:0] swv, string rtag, string stag);
    logic [31:0] r, nf;
    @(negedge clk);
    exec_en = ex; reg_sel = 3'(sel); imm = 7'(k);
    ld_en = ld; ld_sel = 3'(lsel); ld_data = ldv;
    stat_wr_en = sw; stat_wr_data = swv;
    nf = add_flags(m_rf[sel], 7'(k), m_st, r);
    if (ld && !(ex && lsel == sel)) m_rf[lsel] = ldv;
    if (ex) m_rf[sel] = r;
    if (sw) m_st = swv;
    else if (ex) m_st = nf;
    @(negedge clk);
    exec_en = 0; ld_en = 0; stat_wr_en = 0;
    check_all(rtag, stag);
  endtask

  task automatic load(int sel, logic [31:0] v);
    step(0, 0, 0, 1, sel, v, 0, 0, "R9 load", "R9 load flags");
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_st = '0;
    repeat (2) @(negedge clk);
    check_all("R10 reset regs", "R10 reset status");
    rst_n = 1'b1;

    step(1, 0, 0, 0, 0, 0, 0, 0, "R1", "R2 zero+0");
    check("R2 zero flag", status & 32'h7F, 32'h01);
    step(1, 0, 1, 0, 0, 0, 0, 0, "R1", "R2 nonzero");
    step(1, 0, -1, 0, 0, 0, 0, 0, "R1", "R4 carry to zero");
    check("R4 carry+dup+zero", status & 32'h7F, 32'h0D);
    step(1, 0, -1, 0, 0, 0, 0, 0, "R1", "R3 negative");
    check("R3 neg no carry", status & 32'h7F, 32'h02);

    load(3, 32'h7FFF_FFFF);
    step(1, 3, 1, 0, 0, 0, 0, 0, "R1", "R5 ovf up");
    check("R5 ovf+neg+sticky", status & 32'h7F, 32'h72);
    step(1, 3, -1, 0, 0, 0, 0, 0, "R1", "R5 ovf down");
    check("R5 ovf+carry", status & 32'h7F, 32'h7C);
    step(1, 3, -1, 0, 0, 0, 0, 0, "R1", "R6 sticky holds");
    check("R6 sticky stays", status & 32'h7F, 32'h4C);

    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R7", "R7 clear");
    check("R7 cleared", status, 32'h0);
    step(0, 0, 0, 0, 0, 0, 1, 32'hA5A5_FF80, "R7", "R7 preset");
    step(1, 3, 1, 0, 0, 0, 0, 0, "R1", "R8 upper kept");
    check("R8 upper bits", status & 32'hFFFF_FF80, 32'hA5A5_FF80);

    load(5, 32'h8000_0000);
    step(1, 5, -1, 0, 0, 0, 1, 32'h0000_0001, "R7 add still writes", "R7 write beats add");
    check("R7 reg written", regs_flat[5*32 +: 32], 32'h7FFF_FFFF);
    step(1, 2, 5, 1, 2, 32'hDEAD_BEEF, 0, 0, "R9 add beats load", "R9 flags");
    check("R9 same reg", regs_flat[2*32 +: 32], 32'h0000_0005);
    step(0, 6, 9, 0, 0, 0, 0, 0, "R11 idle regs", "R11 idle status");

    for (int n = 0; n < 400; n++) begin
      int sel, k, ls;
      bit ex, ld, sw;
      logic [31:0] v;
      sel = int'($urandom_range(0, 7));
      ls  = int'($urandom_range(0, 7));
      k   = int'($urandom_range(0, 127));
      ex  = ($urandom_range(0, 3) != 0);
      ld  = ($urandom_range(0, 4) == 0);
      sw  = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 3))
        0: v = 32'h7FFF_FFC0 + $urandom_range(0, 127);
        1: v = 32'h8000_0000 - $urandom_range(0, 63);
        2: v = 32'hFFFF_FFC0 + $urandom_range(0, 63);
        default: v = $urandom;
      endcase
      step(ex, sel, k, ld, ls, v, sw, $urandom, "R1/R9 random", "R2/R3/R4/R5/R6/R7/R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule